// File: doc/BRIEF.md
# Search Triplet Step Controller

This block carries out a single step of the device-address search on a single-wire bus. Each command runs two read slots: the first samples the address bit that the devices on the bus share, and the second samples its complement. The block then picks a branch direction from the two samples and, unless they show a collision, sends that direction back on the bus in a write slot. It reports a 3-bit status and pulses a done strobe.

The block does not time any bus waveform. It asks a separate bit-slot generator for each slot with a one-cycle request pulse. The request carries the slot type (read or write) and the bit to write. The generator answers with a one-cycle done pulse, and for a read slot it returns the sampled line level along with that pulse. The outer search loop supplies the preferred direction for the case where both samples are zero. It also keeps its own discrepancy bookkeeping across the address bits.

Top module: `triplet_search_step`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `slot_req_o` are all 0.
- R2: A `start_i` seen while idle is accepted. In the next cycle `busy_o` is 1 and a read slot is requested (`slot_req_o`=1, `slot_wr_o`=0).
- R3: Every slot request is a single-cycle pulse. Exactly two read slots are issued per command, in order. The level returned by the first is taken as the id bit, and the level returned by the second is taken as the complement bit.
- R4: If both samples are 1, the status is 3'b011 and no write slot is issued.
- R5: If both samples are 0, the direction taken is `dir_i` as sampled when the command was accepted. One write slot carries that bit on `slot_bit_o`, and the status is 3'b100 for direction 1 and 3'b000 for direction 0.
- R6: If exactly one sample is 1, the direction taken equals the id bit, and one write slot carries it. The status is 3'b101 when the id bit is 1 and 3'b010 when it is 0.
- R7: Status encoding: bit 0 is the id bit, bit 1 is the complement bit, and bit 2 is the direction taken. The values 3'b001, 3'b110 and 3'b111 never appear.
- R8: Each accepted command produces exactly one `done_o` pulse, one cycle wide. `status_o` is valid in that cycle, and `busy_o` returns to 0 in the next cycle.
- R9: A `start_i` seen while `busy_o` is 1 is ignored. It adds no slot and no done pulse.
- R10: A change on `dir_i` after the command has been accepted does not change the direction that is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start one triplet step (taken only when idle) |
| dir_i | input | 1 | Direction to use when both samples are 0 |
| busy_o | output | 1 | A command is in progress |
| done_o | output | 1 | One-cycle completion strobe |
| status_o | output | 3 | {direction taken, complement bit, id bit} |
| slot_req_o | output | 1 | One-cycle request for a bus slot |
| slot_wr_o | output | 1 | Slot type: 1 = write slot, 0 = read slot |
| slot_bit_o | output | 1 | Bit to send in a write slot |
| slot_done_i | input | 1 | Slot completion pulse from the slot generator |
| slot_rd_i | input | 1 | Sampled line level, valid with `slot_done_i` of a read slot |

## Verification
The bench covers all four sample pairs and both direction inputs. The slot generator answers after random delays, and the bench counts read and write slots and records the bit written. A design that writes after a collision shows a write slot where none should be. A design that swaps the id and complement bits returns 3'b010 where 3'b101 is expected. Two further cases are driven on purpose: `dir_i` is flipped right after acceptance, and a second start is pulsed mid-command. A design that reads `dir_i` late writes the wrong bit in the first case. A design that accepts the second start shows extra slots or a second done pulse.

// File: rtl/triplet_pkg.sv
package triplet_pkg;
  localparam int unsigned STATUS_W = 3;
  localparam int unsigned ST_ID    = 0;
  localparam int unsigned ST_CMP   = 1;
  localparam int unsigned ST_DIR   = 2;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_ID,
    S_RD_CMP,
    S_WR_DIR,
    S_FIN
  } trip_state_e;
endpackage

// File: rtl/triplet_decide.sv
module triplet_decide
  import triplet_pkg::*;
(
  input  logic                id_i,
  input  logic                cmp_i,
  input  logic                pref_i,
  output logic                err_o,
  output logic                dir_o,
  output logic [STATUS_W-1:0] status_o
);
  always_comb begin
    err_o = id_i & cmp_i;
    dir_o = (id_i ^ cmp_i) ? id_i : pref_i;
    status_o = '0;
    status_o[ST_ID]  = id_i;
    status_o[ST_CMP] = cmp_i;
    status_o[ST_DIR] = err_o ? 1'b0 : dir_o;
  end

  always_comb begin
    a_r6_follow_id: assert (!(id_i ^ cmp_i) || (dir_o == id_i));
  end
endmodule

// File: rtl/triplet_seq.sv
module triplet_seq
  import triplet_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                dir_i,
  input  logic                slot_done_i,
  input  logic                slot_rd_i,
  input  logic                dec_err_i,
  input  logic                dec_dir_i,
  input  logic [STATUS_W-1:0] dec_status_i,
  output logic                id_o,
  output logic                pref_o,
  output logic                busy_o,
  output logic                done_o,
  output logic [STATUS_W-1:0] status_o,
  output logic                slot_req_o,
  output logic                slot_wr_o,
  output logic                slot_bit_o
);
  trip_state_e state_q;
  logic        pend_q;
  logic        id_q, cmp_q, pref_q, dir_q;
  logic [STATUS_W-1:0] status_q;
  logic        slot_end;

  // a done pulse only counts once the request pulse has gone out
  assign slot_end = slot_done_i & ~pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      pend_q   <= 1'b0;
      id_q     <= 1'b0;
      cmp_q    <= 1'b0;
      pref_q   <= 1'b0;
      dir_q    <= 1'b0;
      status_q <= '0;
    end else begin
      pend_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          pref_q  <= dir_i;
          pend_q  <= 1'b1;
          state_q <= S_RD_ID;
        end
        S_RD_ID: if (slot_end) begin
          id_q    <= slot_rd_i;
          pend_q  <= 1'b1;
          state_q <= S_RD_CMP;
        end
        S_RD_CMP: if (slot_end) begin
          cmp_q    <= slot_rd_i;
          dir_q    <= dec_dir_i;
          status_q <= dec_status_i;
          if (dec_err_i) begin
            state_q <= S_FIN;
          end else begin
            pend_q  <= 1'b1;
            state_q <= S_WR_DIR;
          end
        end
        S_WR_DIR: if (slot_end) state_q <= S_FIN;
        S_FIN:    state_q <= S_IDLE;
        default:  state_q <= S_IDLE;
      endcase
    end
  end

  assign id_o       = id_q;
  assign pref_o     = pref_q;
  assign busy_o     = (state_q != S_IDLE);
  assign done_o     = (state_q == S_FIN);
  assign status_o   = status_q;
  assign slot_req_o = pend_q;
  assign slot_wr_o  = (state_q == S_WR_DIR);
  assign slot_bit_o = (state_q == S_WR_DIR) & dir_q;

  a_r2_first_slot_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (slot_req_o && !slot_wr_o));
  a_r3_req_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_req_o |=> !slot_req_o);
  a_r4_no_write_on_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_req_o && slot_wr_o) |-> !(id_q && cmp_q));
  a_r7_status_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (status_o != 3'b001 && status_o != 3'b110 && status_o != 3'b111));
  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));
  a_r9_busy_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);
endmodule

// File: rtl/triplet_search_step.sv
module triplet_search_step
  import triplet_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                dir_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [STATUS_W-1:0] status_o,
  output logic                slot_req_o,
  output logic                slot_wr_o,
  output logic                slot_bit_o,
  input  logic                slot_done_i,
  input  logic                slot_rd_i
);
  logic                id_w, pref_w, err_w, dir_w;
  logic [STATUS_W-1:0] dec_status_w;

  triplet_decide u_decide (
    .id_i     (id_w),
    .cmp_i    (slot_rd_i),
    .pref_i   (pref_w),
    .err_o    (err_w),
    .dir_o    (dir_w),
    .status_o (dec_status_w)
  );

  triplet_seq u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .dir_i        (dir_i),
    .slot_done_i  (slot_done_i),
    .slot_rd_i    (slot_rd_i),
    .dec_err_i    (err_w),
    .dec_dir_i    (dir_w),
    .dec_status_i (dec_status_w),
    .id_o         (id_w),
    .pref_o       (pref_w),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .status_o     (status_o),
    .slot_req_o   (slot_req_o),
    .slot_wr_o    (slot_wr_o),
    .slot_bit_o   (slot_bit_o)
  );
endmodule

// File: tb/triplet_search_step_tb_top.sv
module triplet_search_step_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic       dir_i = 1'b0;
  logic       busy_o, done_o, slot_req_o, slot_wr_o, slot_bit_o;
  logic [2:0] status_o;
  logic       slot_done_i = 1'b0;
  logic       slot_rd_i = 1'b0;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;

  logic [1:0] rd_bits;
  int  rd_idx = 0;
  int  n_rd = 0;
  int  n_wr = 0;
  logic wr_bit = 1'b0;
  int  wait_cnt = -1;
  logic pend_wr = 1'b0;

  always #4 clk_i = ~clk_i;

  triplet_search_step dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .dir_i(dir_i),
    .busy_o(busy_o), .done_o(done_o), .status_o(status_o),
    .slot_req_o(slot_req_o), .slot_wr_o(slot_wr_o), .slot_bit_o(slot_bit_o),
    .slot_done_i(slot_done_i), .slot_rd_i(slot_rd_i)
  );

  // slot generator model, answers after 1..4 cycles
  always @(negedge clk_i) begin
    cycles++;
    if (slot_done_i) slot_done_i = 1'b0;
    if (wait_cnt > 0) wait_cnt--;
    else if (wait_cnt == 0) begin
      slot_done_i = 1'b1;
      slot_rd_i = pend_wr ? 1'b0 : ((rd_idx < 2) ? rd_bits[rd_idx] : 1'b1);
      if (!pend_wr) rd_idx++;
      wait_cnt = -1;
    end
    if (slot_req_o) begin
      if (slot_wr_o) begin n_wr++; wr_bit = slot_bit_o; end
      else n_rd++;
      pend_wr = slot_wr_o;
      wait_cnt = $urandom_range(0, 3);
    end
  end

  function automatic logic [2:0] exp_status(logic id, logic cmp, logic dir);
    if (id && cmp) return 3'b011;
    if (id ^ cmp) return {id, cmp, id};
    return {dir, 2'b00};
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input logic id, input logic cmp, input logic dir, input logic flip, input logic extra);
    int ndone = 0;
    logic [2:0] st = 3'b000;
    logic [2:0] ex;
    logic dtake;
    ex = exp_status(id, cmp, dir);
    dtake = (id ^ cmp) ? id : dir;
    rd_bits = {cmp, id};
    rd_idx = 0; n_rd = 0; n_wr = 0;
    dir_i = dir;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    if (flip) dir_i = ~dir;
    check(busy_o && slot_req_o && !slot_wr_o, "R2", {busy_o, slot_req_o, slot_wr_o}, 3'b110);
    for (int i = 0; i < 40; i++) begin
      if (extra && i == 2) start_i = 1'b1;
      if (extra && i == 3) start_i = 1'b0;
      @(negedge clk_i);
      if (done_o) begin ndone++; st = status_o; end
    end
    check(st == ex, "R7 status", st, ex);
    if (id && cmp) check(n_wr == 0, "R4 no write", n_wr, 0);
    else if (id ^ cmp) check(n_wr == 1 && wr_bit == id, "R6 follow id", {n_wr[1:0], wr_bit}, {2'd1, id});
    else check(n_wr == 1 && wr_bit == dir, flip ? "R10 dir held" : "R5 pref dir",
               {n_wr[1:0], wr_bit}, {2'd1, dir});
    check(n_rd == 2, extra ? "R9 slots" : "R3 reads", n_rd, 2);
    check(ndone == 1, extra ? "R9 done" : "R8 done", ndone, 1);
    check(!busy_o, "R8 idle", busy_o, 0);
    if (dtake != ex[2] && !(id && cmp)) check(1'b0, "R7 dir bit", ex[2], dtake);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    check(!busy_o && !done_o && !slot_req_o, "R1", {busy_o, done_o, slot_req_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!busy_o && !done_o && !slot_req_o, "R1 after release", {busy_o, done_o, slot_req_o}, 0);
    for (int k = 0; k < 8; k++) run(k[0], k[1], k[2], 1'b0, 1'b0);
    run(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);  // R10
    run(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);  // R10
    run(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);  // R9
    run(1'b1, 1'b1, 1'b0, 1'b0, 1'b1);  // R9
    for (int k = 0; k < 150; k++) begin
      logic [4:0] r;
      r = 5'($urandom());
      run(r[0], r[1], r[2], r[3], r[4]);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule